// File: doc/BRIEF.md
# Stepped-Ramp Duty Cycle Generator

This block drives one pulse-width-modulated gate line. A free-running divider sets the PWM period, and its top bits index a descending staircase of 16 equal levels. A 4-bit feedback code is compared against that staircase: the gate is on while the current level lies above the feedback and off once the staircase has fallen to or below it. Lower feedback therefore gives a longer on-time. Two range flags stand in for feedback that falls outside the staircase. One flag forces the gate fully on for the whole period. The other forces it fully off.

The feedback code and both flags are captured once, at the first clock of each period, so the duty cycle cannot change partway through a period. A test-mode input shortens the period from 256 to 16 clocks. In that mode the step index comes from the low divider bits, so all 16 levels still appear in every period. The tick, step index and gate outputs are registered. They show the divider state one clock after it occurs.

Top module: `stair_pwm`

## Requirements
- R1: While `rst` is high at a rising edge, the divider returns to zero, and after that edge `gate`, `period_tick` and `step_idx` are all zero. The first rising edge with `rst` low starts a new period, and one clock later `period_tick` is 1 and `step_idx` is 0.
- R2: With `test_mode` low, `period_tick` is high for exactly one clock in every 256 and low at all other times.
- R3: With `test_mode` low, `step_idx` counts 0 to 15 and holds each value for 16 clocks. It wraps to 0 together with `period_tick`. The staircase level of step s is 15 - s, so step 0 is the highest level.
- R4: With both flags low at the period start, `gate` is 1 exactly while step s satisfies 15 - s > `fb_code`. A code f gives (15 - f) steps of on-time per period, so a code of 15 gives no on-time.
- R5: With `fb_below` = 1 and `fb_above` = 0 at the period start, `gate` is 1 for the whole period.
- R6: With `fb_above` = 1 at the period start, `gate` is 0 for the whole period, whatever `fb_below` and `fb_code` are.
- R7: `fb_code`, `fb_below` and `fb_above` are used only in the clock that begins a period. Changes at any other clock have no effect on `gate` until the next period.
- R8: With `test_mode` high, the period is 16 clocks. `step_idx` advances by one every clock from 0 to 15, `period_tick` is high once per 16 clocks with `step_idx` 0, and R4 to R7 apply per 16-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects the 16-clock accelerated period |
| fb_code | input | 4 | Digitized feedback level |
| fb_below | input | 1 | Feedback lies below the lowest staircase level |
| fb_above | input | 1 | Feedback lies above the highest staircase level |
| gate | output | 1 | Registered PWM gate output |
| period_tick | output | 1 | One-clock pulse at the first step of each period |
| step_idx | output | 4 | Current staircase step, 0 = highest level |

## Verification
The most delicate cycle is the period boundary. In that one clock the new feedback is captured and also decides the gate for step 0, so both the capture and the comparison use the value present on that edge. The bench changes the feedback code and flags on every clock in its random phases, so boundaries routinely meet fresh values. It compares every output against a model that holds the sampled values for the whole period. Directed periods change the inputs right after the boundary clock and then measure the on-time of the whole period. This shows that the change is ignored, and that flag priority and in-range duty give the expected number of on-clocks.

// File: rtl/stair_pwm_pkg.sv
package stair_pwm_pkg;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_STEP_W = 4;

  typedef enum logic {
    RATE_NORMAL = 1'b0,
    RATE_FAST   = 1'b1
  } rate_e;

  typedef struct packed {
    logic low_force;
    logic high_force;
  } range_t;
endpackage

// File: rtl/stair_divider.sv
module stair_divider
  import stair_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned STEP_W = DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  rate_e             rate,
  output logic [STEP_W-1:0] step,
  output logic              start
);
  localparam int unsigned TOP_LSB = CNT_W - STEP_W;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (rate == RATE_FAST) begin
      step  = cnt[STEP_W-1:0];
      start = (cnt[STEP_W-1:0] == '0);
    end else begin
      step  = cnt[CNT_W-1:TOP_LSB];
      start = (cnt == '0);
    end
  end
endmodule

// File: rtl/stair_sampler.sv
module stair_sampler
  import stair_pwm_pkg::*;
#(
  parameter int unsigned STEP_W = DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] code_in,
  input  range_t            range_in,
  output logic [STEP_W-1:0] code_eff,
  output range_t            range_eff
);
  logic [STEP_W-1:0] code_q;
  range_t            range_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      range_q <= '0;
    end else if (start) begin
      code_q  <= code_in;
      range_q <= range_in;
    end
  end

  // The boundary clock uses the fresh value; later clocks use the held copy.
  assign code_eff  = start ? code_in  : code_q;
  assign range_eff = start ? range_in : range_q;
endmodule

// File: rtl/stair_gate.sv
module stair_gate
  import stair_pwm_pkg::*;
#(
  parameter int unsigned STEP_W = DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  input  logic              start,
  input  logic [STEP_W-1:0] code,
  input  range_t            range,
  output logic              gate_q,
  output logic              tick_q,
  output logic [STEP_W-1:0] step_q
);
  localparam logic [STEP_W-1:0] TOP_LEVEL = {STEP_W{1'b1}};

  logic [STEP_W-1:0] level;
  logic              on_next;

  assign level = TOP_LEVEL - step;

  always_comb begin
    if (range.high_force)     on_next = 1'b0;
    else if (range.low_force) on_next = 1'b1;
    else                      on_next = (level > code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      tick_q <= 1'b0;
      step_q <= '0;
    end else begin
      gate_q <= on_next;
      tick_q <= start;
      step_q <= step;
    end
  end
endmodule

// File: rtl/stair_pwm.sv
module stair_pwm
  import stair_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned STEP_W = DEF_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic [STEP_W-1:0] fb_code,
  input  logic              fb_below,
  input  logic              fb_above,
  output logic              gate,
  output logic              period_tick,
  output logic [STEP_W-1:0] step_idx
);
  rate_e             rate;
  logic [STEP_W-1:0] step;
  logic              start;
  logic [STEP_W-1:0] code_eff;
  range_t            range_in;
  range_t            range_eff;

  assign rate     = test_mode ? RATE_FAST : RATE_NORMAL;
  assign range_in = '{low_force: fb_below, high_force: fb_above};

  stair_divider #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .rate (rate),
    .step (step),
    .start(start)
  );

  stair_sampler #(.STEP_W(STEP_W)) u_smp (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .code_in  (fb_code),
    .range_in (range_in),
    .code_eff (code_eff),
    .range_eff(range_eff)
  );

  stair_gate #(.STEP_W(STEP_W)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .start (start),
    .code  (code_eff),
    .range (range_eff),
    .gate_q(gate),
    .tick_q(period_tick),
    .step_q(step_idx)
  );
endmodule

// File: rtl/stair_pwm_chk.sv
module stair_pwm_chk #(
  parameter int unsigned STEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              test_mode,
  input logic [STEP_W-1:0] fb_code,
  input logic              fb_below,
  input logic              fb_above,
  input logic              gate,
  input logic              period_tick,
  input logic [STEP_W-1:0] step_idx
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!gate && !period_tick && step_idx == '0));

  assert_tick_on_first_step_R2: assert property (@(posedge clk) disable iff (rst)
    period_tick |-> (step_idx == '0));

  assert_step_moves_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(test_mode) && !$past(rst) && step_idx != $past(step_idx))
      |-> (step_idx == STEP_W'($past(step_idx) + 1'b1)));

  assert_top_code_no_on_time_R4: assert property (@(posedge clk) disable iff (rst)
    (period_tick && !$past(fb_below) && !$past(fb_above) && $past(fb_code) == {STEP_W{1'b1}})
      |-> !gate);

  assert_below_forces_on_R5: assert property (@(posedge clk) disable iff (rst)
    (period_tick && $past(fb_below) && !$past(fb_above)) |-> gate);

  assert_above_forces_off_R6: assert property (@(posedge clk) disable iff (rst)
    (period_tick && $past(fb_above)) |-> !gate);

  assert_fast_step_each_clock_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(test_mode) && $past(test_mode, 2) && !$past(rst) && !$past(rst, 2))
      |-> (step_idx == STEP_W'($past(step_idx) + 1'b1)));
endmodule

bind stair_pwm stair_pwm_chk #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .test_mode  (test_mode),
  .fb_code    (fb_code),
  .fb_below   (fb_below),
  .fb_above   (fb_above),
  .gate       (gate),
  .period_tick(period_tick),
  .step_idx   (step_idx)
);

// File: tb/test_stair_pwm.sv
module test_stair_pwm;
  logic       clk = 1'b0;
  logic       rst;
  logic       test_mode;
  logic [3:0] fb_code;
  logic       fb_below;
  logic       fb_above;
  logic       gate;
  logic       period_tick;
  logic [3:0] step_idx;

  always #5 clk = ~clk;

  stair_pwm i_stair_pwm (
    .clk(clk), .rst(rst), .test_mode(test_mode), .fb_code(fb_code),
    .fb_below(fb_below), .fb_above(fb_above), .gate(gate),
    .period_tick(period_tick), .step_idx(step_idx)
  );

  int checks = 0;
  int fails  = 0;
  int seed_v;

  // model state
  int         m_cnt = 0;
  logic [3:0] m_fb  = 4'd0;
  logic       m_lo  = 1'b0;
  logic       m_hi  = 1'b0;
  logic       exp_gate, exp_tick;
  logic [3:0] exp_step;
  string      tag_g, tag_t, tag_s;
  logic       armed = 1'b0;
  int         acc = 0;
  int         last_duty = 0;

  function automatic logic ref_gate(logic [3:0] s, logic [3:0] f, logic lo, logic hi);
    if (hi)      return 1'b0;
    else if (lo) return 1'b1;
    else         return ((4'd15 - s) > f);
  endfunction

  task automatic check(string tag, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  // One clock: check outputs of the previous edge, then drive inputs for the next edge.
  task automatic cycle(logic r, logic t, logic [3:0] f, logic lo, logic hi);
    logic [3:0] s;
    logic       st;
    @(negedge clk);
    if (armed) begin
      check(tag_g, int'(gate), int'(exp_gate), "gate");
      check(tag_t, int'(period_tick), int'(exp_tick), "period_tick");
      check(tag_s, int'(step_idx), int'(exp_step), "step_idx");
    end
    if (period_tick) begin
      last_duty = acc;
      acc = int'(gate);
    end else begin
      acc += int'(gate);
    end
    rst = r; test_mode = t; fb_code = f; fb_below = lo; fb_above = hi;
    if (r) begin
      m_cnt = 0; m_fb = 4'd0; m_lo = 1'b0; m_hi = 1'b0;
      exp_gate = 1'b0; exp_tick = 1'b0; exp_step = 4'd0;
      tag_g = "R1"; tag_t = "R1"; tag_s = "R1";
    end else begin
      s  = t ? 4'(m_cnt % 16) : 4'(m_cnt / 16);
      st = t ? ((m_cnt % 16) == 0) : (m_cnt == 0);
      if (st) begin m_fb = f; m_lo = lo; m_hi = hi; end
      exp_tick = st;
      exp_step = s;
      exp_gate = ref_gate(s, m_fb, m_lo, m_hi);
      tag_t = t ? "R8" : "R2";
      tag_s = t ? "R8" : "R3";
      tag_g = m_hi ? "R6" : (m_lo ? "R5" : "R4");
      m_cnt = (m_cnt + 1) % 256;
    end
    armed = 1'b1;
  endtask

  task automatic do_reset(logic t);
    for (int i = 0; i < 3; i++) cycle(1'b1, t, 4'd0, 1'b0, 1'b0);
  endtask

  // First clock uses (f0,lo0,hi0), the rest (f1,lo1,hi1); prev = on-time of the prior period.
  task automatic run_period(int len, logic t,
                            logic [3:0] f0, logic lo0, logic hi0,
                            logic [3:0] f1, logic lo1, logic hi1,
                            output int prev);
    prev = -1;
    for (int i = 0; i < len; i++) begin
      if (i == 0) cycle(1'b0, t, f0, lo0, hi0);
      else        cycle(1'b0, t, f1, lo1, hi1);
      if (i == 1) prev = last_duty;
    end
  endtask

  task automatic random_run(int n, logic t);
    for (int i = 0; i < n; i++) begin
      logic [3:0] f;
      logic lo, hi;
      f  = 4'($urandom_range(0, 15));
      lo = ($urandom_range(0, 7) == 0);
      hi = ($urandom_range(0, 7) == 0);
      cycle(1'b0, t, f, lo, hi);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int p;
    seed_v = $urandom(1234);
    rst = 1'b1; test_mode = 1'b0; fb_code = 4'd0; fb_below = 1'b0; fb_above = 1'b0;
    @(negedge clk);
    // R1 reset state, normal rate
    do_reset(1'b0);
    check("R1", int'(gate), 0, "gate in reset");
    // R7: start with code 15 (no on-time), change to 0 after the boundary
    run_period(256, 1'b0, 4'd15, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, p);
    run_period(256, 1'b0, 4'd0, 1'b0, 1'b0, 4'd15, 1'b1, 1'b1, p);
    check("R7", p, 0, "on-time after mid-period change");
    run_period(256, 1'b0, 4'd9, 1'b1, 1'b0, 4'd15, 1'b0, 1'b1, p);
    check("R4", p, 240, "on-time for code 0");
    run_period(256, 1'b0, 4'd7, 1'b1, 1'b1, 4'd0, 1'b1, 1'b0, p);
    check("R5", p, 256, "on-time with low flag");
    run_period(256, 1'b0, 4'd5, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, p);
    check("R6", p, 0, "on-time with both flags");
    run_period(256, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, p);
    check("R4", p, 160, "on-time for code 5");
    random_run(3000, 1'b0);
    // R8 accelerated rate
    do_reset(1'b1);
    run_period(16, 1'b1, 4'd3, 1'b0, 1'b0, 4'd15, 1'b1, 1'b0, p);
    run_period(16, 1'b1, 4'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, p);
    check("R8", p, 12, "fast on-time for code 3");
    run_period(16, 1'b1, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, p);
    check("R8", p, 16, "fast on-time with low flag");
    run_period(16, 1'b1, 4'd14, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, p);
    check("R8", p, 0, "fast on-time with high flag");
    run_period(16, 1'b1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, p);
    check("R8", p, 1, "fast on-time for code 14");
    random_run(2000, 1'b1);
    // R1 reset in the middle of a period, then the normal rate again
    do_reset(1'b0);
    check("R1", int'(step_idx), 0, "step_idx after mid-run reset");
    random_run(1500, 1'b0);
    cycle(1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    finish_run();
  end
endmodule